// File: doc/BRIEF.md
# Classifier-Gated Binary Content-Addressable Memory

This block is an exact-match lookup table for tags. Each entry holds a full-width tag and a valid bit. A search returns whether any valid entry equals the search tag and, if so, the lowest such entry index. The entries are grouped into sub-blocks of consecutive indices. A full-tag compare runs only in the sub-blocks that a trained predictor enables for the current search.

The predictor works on the low bits of the tag, called the short key, which is cut into equal slices. Each slice addresses a row in its own small bit memory, and each row has one column per entry. A write sets the entry's column in every slice row that its short key selects. A search reads one row per slice, ANDs the rows column by column and ORs the result within each sub-block. This gives one compare-enable per sub-block.

The predictor may enable a sub-block that holds no real match, and the full compare filters those out. It never withholds an enable from a sub-block that holds a real match. An invalidate clears the entry's valid bit at once. It then removes the entry's predictor bits, one slice per cycle. The block reports how many sub-blocks each search enabled, so the amount of gating can be observed.

Top module: `cgcam_top`

## Requirements
- R1: After reset no entry is valid and resValid, resHit, resIdx and resEnCount are all 0. A search before any write returns a miss with resEnCount 0.
- R2: A search sampled on clock edge k gives resValid = 1 after edge k+1 and resValid = 0 after edge k alone. A valid stored tag searched with its exact value gives resHit = 1 and resIdx = its entry index.
- R3: A search for a tag held by no valid entry gives resValid = 1, resHit = 0 and resIdx = 0.
- R4: When several valid entries hold the search tag, resIdx is the lowest of their indices.
- R5: When a write and a search fall in the same cycle, the search sees the new entry. A search in the cycle right after a write also sees it.
- R6: An invalidate accepted in the same cycle as a search already hides the entry from that search. Other entries keep matching.
- R7: Sub-block g holds entries GROUP*g to GROUP*g+GROUP-1. resEnCount is the number of sub-blocks enabled for the search. Suppose no entry has been overwritten or invalidated since reset. Then resEnCount is the number of sub-blocks that hold a written entry whose low SHORT_W bits equal those of the search tag. An entry whose short key matches in only some slices does not count.
- R8: An entry whose low SHORT_W bits equal the search tag but whose full tag differs may raise resEnCount. It never produces a hit.
- R9: Overwriting an entry with a new tag makes the old tag miss and the new tag hit. Predictor bits left over from the old tag may still enable its sub-block.
- R10: Suppose an entry is invalidated and no write to it follows within NUM_SLICES cycles. Its bits are then removed from the predictor, so its sub-block is no longer enabled for its old tag unless another entry there still qualifies.
- R11: A write to an entry whose invalidate clean-up is still running stops that clean-up. The rewritten entry then hits for its tag, so no false negative appears.
- R12: An invalidate and a write to the same entry in the same cycle resolve as the write. The entry holds the new tag, and its old predictor bits are left in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Store wrTag at entry wrAddr and train the predictor |
| wrAddr | input | IDX_W | Entry index for the write |
| wrTag | input | TAG_W | Tag to store |
| invEn | input | 1 | Invalidate entry invAddr |
| invAddr | input | IDX_W | Entry index for the invalidate |
| srchEn | input | 1 | Start a search |
| srchTag | input | TAG_W | Tag to look up |
| resValid | output | 1 | Search result present (two cycles after srchEn) |
| resHit | output | 1 | A valid entry matched |
| resIdx | output | IDX_W | Lowest matching entry index, 0 on a miss |
| resEnCount | output | CNT_W | Number of sub-blocks enabled for this search |

## Verification
Two collisions can occur in the same cycle. The first is a write and a search, or a write and an invalidate, that target the same entry. The second is a write to an entry whose slice-by-slice predictor clean-up is still running. The bench raises the write, invalidate and search strobes together in one cycle. It also places a rewrite in the exact cycle when the second slice of an invalidated entry would be cleared. It judges the outcome only at the result ports. The expected hit, index and sub-block count are worked out from the write-first rule and the short-key equality rule.

// File: rtl/cgcam_pkg.sv
package cgcam_pkg;

  // Strobes issued by the control unit to the datapath each cycle.
  typedef struct packed {
    logic wrSet;     // store tag and set predictor bits
    logic invValid;  // clear the valid bit of the invalidated entry
    logic clrEn;     // clear one predictor bit (one slice per cycle)
  } ctrl_strb_t;

endpackage

// File: rtl/cgcam_ctrl.sv
module cgcam_ctrl
  import cgcam_pkg::*;
#(
  parameter int NUM_ENTRIES = 64,
  parameter int SHORT_W     = 8,
  parameter int NUM_SLICES  = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [IDX_W-1:0]          wrAddr,
  input  logic                      invEn,
  input  logic [IDX_W-1:0]          invAddr,
  input  logic [SHORT_W-1:0]        rdShort,
  output ctrl_strb_t                strb,
  output logic [SLICE_IDX_W-1:0]    clrSlice,
  output logic [SLICE_W-1:0]        clrRow,
  output logic [IDX_W-1:0]          clrCol
);
  localparam int IDX_W       = $clog2(NUM_ENTRIES);
  localparam int SLICE_W     = SHORT_W / NUM_SLICES;
  localparam int SLICE_IDX_W = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1;
  localparam logic [SLICE_IDX_W-1:0] LAST_SLICE = SLICE_IDX_W'(NUM_SLICES - 1);

  logic               clrActive;
  logic [SHORT_W-1:0] clrShort;
  logic               wrHitsInv;
  logic               wrHitsClr;
  logic               invAccept;

  always_comb begin
    wrHitsInv     = wrEn && (wrAddr == invAddr);
    wrHitsClr     = wrEn && (wrAddr == clrCol);
    invAccept     = invEn && !wrHitsInv;
    strb.wrSet    = wrEn;
    strb.invValid = invAccept;
    strb.clrEn    = clrActive && !wrHitsClr;
    clrRow        = clrShort[clrSlice*SLICE_W +: SLICE_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clrActive <= 1'b0;
      clrSlice  <= '0;
      clrCol    <= '0;
      clrShort  <= '0;
    end else if (invAccept) begin
      clrActive <= 1'b1;
      clrSlice  <= '0;
      clrCol    <= invAddr;
      clrShort  <= rdShort;
    end else if (clrActive) begin
      if (wrHitsClr || clrSlice == LAST_SLICE) begin
        clrActive <= 1'b0;
      end else begin
        clrSlice <= clrSlice + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cgcam_classifier.sv
module cgcam_classifier #(
  parameter int NUM_ENTRIES = 64,
  parameter int SHORT_W     = 8,
  parameter int NUM_SLICES  = 2,
  parameter int GROUP       = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrSet,
  input  logic [IDX_W-1:0]        wrAddr,
  input  logic [SHORT_W-1:0]      wrShort,
  input  logic                    clrEn,
  input  logic [SLICE_IDX_W-1:0]  clrSlice,
  input  logic [SLICE_W-1:0]      clrRow,
  input  logic [IDX_W-1:0]        clrCol,
  input  logic                    srchEn,
  input  logic [SHORT_W-1:0]      srchShort,
  output logic [NUM_GROUPS-1:0]   grpEnQ
);
  localparam int IDX_W       = $clog2(NUM_ENTRIES);
  localparam int SLICE_W     = SHORT_W / NUM_SLICES;
  localparam int ROWS        = 1 << SLICE_W;
  localparam int NUM_GROUPS  = NUM_ENTRIES / GROUP;
  localparam int SLICE_IDX_W = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1;

  logic [NUM_ENTRIES-1:0] rowBits [NUM_SLICES];
  logic [NUM_ENTRIES-1:0] wrOneHot;
  logic [NUM_ENTRIES-1:0] cand;
  logic [NUM_GROUPS-1:0]  grpEn;

  assign wrOneHot = NUM_ENTRIES'(1) << wrAddr;

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    logic [NUM_ENTRIES-1:0] conn [ROWS];
    logic [SLICE_W-1:0]     wrRow;
    logic [SLICE_W-1:0]     rdRow;
    logic                   clrHere;

    assign wrRow   = wrShort[s*SLICE_W +: SLICE_W];
    assign rdRow   = srchShort[s*SLICE_W +: SLICE_W];
    assign clrHere = clrEn && (clrSlice == SLICE_IDX_W'(s));

    // Write-first read: a training write in this cycle is folded in.
    assign rowBits[s] = conn[rdRow] | ((wrSet && wrRow == rdRow) ? wrOneHot : '0);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int r = 0; r < ROWS; r++) conn[r] <= '0;
      end else begin
        if (clrHere) conn[clrRow][clrCol] <= 1'b0;
        if (wrSet)   conn[wrRow][wrAddr]  <= 1'b1;
      end
    end
  end

  always_comb begin
    cand = '1;
    for (int s = 0; s < NUM_SLICES; s++) cand &= rowBits[s];
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
    assign grpEn[g] = |cand[g*GROUP +: GROUP];
  end

  always_ff @(posedge clk) begin
    if (!rstN) grpEnQ <= '0;
    else       grpEnQ <= srchEn ? grpEn : '0;
  end

endmodule

// File: rtl/cgcam_array.sv
module cgcam_array #(
  parameter int NUM_ENTRIES = 64,
  parameter int TAG_W       = 16,
  parameter int SHORT_W     = 8,
  parameter int GROUP       = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrSet,
  input  logic [IDX_W-1:0]       wrAddr,
  input  logic [TAG_W-1:0]       wrTag,
  input  logic                   invValid,
  input  logic [IDX_W-1:0]       invAddr,
  output logic [SHORT_W-1:0]     rdShort,
  input  logic                   srchEn,
  input  logic [TAG_W-1:0]       srchTag,
  input  logic [NUM_GROUPS-1:0]  grpEnQ,
  output logic                   resValid,
  output logic                   resHit,
  output logic [IDX_W-1:0]       resIdx,
  output logic [CNT_W-1:0]       resEnCount
);
  localparam int IDX_W      = $clog2(NUM_ENTRIES);
  localparam int NUM_GROUPS = NUM_ENTRIES / GROUP;
  localparam int CNT_W      = $clog2(NUM_GROUPS + 1);

  logic [TAG_W-1:0]       tags [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] valid;
  logic                   srchValidQ;
  logic [TAG_W-1:0]       srchTagQ;
  logic [NUM_ENTRIES-1:0] hitVec;
  logic                   anyHit;
  logic [IDX_W-1:0]       hitIdx;
  logic [CNT_W-1:0]       enCnt;

  assign rdShort = tags[invAddr][SHORT_W-1:0];

  always_ff @(posedge clk) begin
    if (wrSet) tags[wrAddr] <= wrTag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valid <= '0;
    end else begin
      if (invValid) valid[invAddr] <= 1'b0;
      if (wrSet)    valid[wrAddr]  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srchValidQ <= 1'b0;
      srchTagQ   <= '0;
    end else begin
      srchValidQ <= srchEn;
      srchTagQ   <= srchTag;
    end
  end

  // Compare only inside enabled sub-blocks.
  for (genvar m = 0; m < NUM_ENTRIES; m++) begin : g_cmp
    assign hitVec[m] = grpEnQ[m / GROUP] && valid[m] && (tags[m] == srchTagQ);
  end

  always_comb begin
    anyHit = 1'b0;
    hitIdx = '0;
    for (int m = NUM_ENTRIES - 1; m >= 0; m--) begin
      if (hitVec[m]) begin
        anyHit = 1'b1;
        hitIdx = IDX_W'(m);
      end
    end
  end

  always_comb begin
    enCnt = '0;
    for (int g = 0; g < NUM_GROUPS; g++) enCnt += CNT_W'(grpEnQ[g]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid   <= 1'b0;
      resHit     <= 1'b0;
      resIdx     <= '0;
      resEnCount <= '0;
    end else begin
      resValid   <= srchValidQ;
      resHit     <= srchValidQ && anyHit;
      resIdx     <= (srchValidQ && anyHit) ? hitIdx : '0;
      resEnCount <= srchValidQ ? enCnt : '0;
    end
  end

endmodule

// File: rtl/cgcam_top.sv
module cgcam_top
  import cgcam_pkg::*;
#(
  parameter int NUM_ENTRIES = 64,
  parameter int TAG_W       = 16,
  parameter int SHORT_W     = 8,
  parameter int NUM_SLICES  = 2,
  parameter int GROUP       = 8,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int NUM_GROUPS = NUM_ENTRIES / GROUP,
  localparam int CNT_W      = $clog2(NUM_GROUPS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [TAG_W-1:0]  wrTag,
  input  logic              invEn,
  input  logic [IDX_W-1:0]  invAddr,
  input  logic              srchEn,
  input  logic [TAG_W-1:0]  srchTag,
  output logic              resValid,
  output logic              resHit,
  output logic [IDX_W-1:0]  resIdx,
  output logic [CNT_W-1:0]  resEnCount
);
  localparam int SLICE_W     = SHORT_W / NUM_SLICES;
  localparam int SLICE_IDX_W = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1;

  ctrl_strb_t              ctrlStrb;
  logic [SLICE_IDX_W-1:0]  clrSlice;
  logic [SLICE_W-1:0]      clrRow;
  logic [IDX_W-1:0]        clrCol;
  logic [SHORT_W-1:0]      rdShort;
  logic [NUM_GROUPS-1:0]   grpEnQ;

  cgcam_ctrl #(
    .NUM_ENTRIES(NUM_ENTRIES), .SHORT_W(SHORT_W), .NUM_SLICES(NUM_SLICES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .invEn(invEn), .invAddr(invAddr), .rdShort(rdShort),
    .strb(ctrlStrb), .clrSlice(clrSlice), .clrRow(clrRow), .clrCol(clrCol)
  );

  cgcam_classifier #(
    .NUM_ENTRIES(NUM_ENTRIES), .SHORT_W(SHORT_W),
    .NUM_SLICES(NUM_SLICES), .GROUP(GROUP)
  ) u_cls (
    .clk(clk), .rstN(rstN), .wrSet(ctrlStrb.wrSet), .wrAddr(wrAddr),
    .wrShort(wrTag[SHORT_W-1:0]), .clrEn(ctrlStrb.clrEn), .clrSlice(clrSlice),
    .clrRow(clrRow), .clrCol(clrCol), .srchEn(srchEn),
    .srchShort(srchTag[SHORT_W-1:0]), .grpEnQ(grpEnQ)
  );

  cgcam_array #(
    .NUM_ENTRIES(NUM_ENTRIES), .TAG_W(TAG_W), .SHORT_W(SHORT_W), .GROUP(GROUP)
  ) u_arr (
    .clk(clk), .rstN(rstN), .wrSet(ctrlStrb.wrSet), .wrAddr(wrAddr),
    .wrTag(wrTag), .invValid(ctrlStrb.invValid), .invAddr(invAddr),
    .rdShort(rdShort), .srchEn(srchEn), .srchTag(srchTag), .grpEnQ(grpEnQ),
    .resValid(resValid), .resHit(resHit), .resIdx(resIdx),
    .resEnCount(resEnCount)
  );

endmodule

// File: rtl/cgcam_chk.sv
module cgcam_chk #(
  parameter int IDX_W      = 6,
  parameter int NUM_GROUPS = 8,
  parameter int CNT_W      = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              srchEn,
  input logic              wrSet,
  input logic [IDX_W-1:0]  wrAddr,
  input logic              clrEn,
  input logic [IDX_W-1:0]  clrCol,
  input logic              resValid,
  input logic              resHit,
  input logic [CNT_W-1:0]  resEnCount
);

  // R2
  res_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    srchEn |-> ##2 resValid);

  // R3
  hit_needs_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    resHit |-> resValid);

  // R7
  hit_has_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    resHit |-> (resEnCount != '0));

  // R7
  count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    resEnCount <= CNT_W'(NUM_GROUPS));

  // R11
  clear_spares_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrEn && wrSet) |-> (clrCol != wrAddr));

endmodule

bind cgcam_top cgcam_chk #(
  .IDX_W(IDX_W), .NUM_GROUPS(NUM_GROUPS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .srchEn(srchEn),
  .wrSet(ctrlStrb.wrSet), .wrAddr(wrAddr),
  .clrEn(ctrlStrb.clrEn), .clrCol(clrCol),
  .resValid(resValid), .resHit(resHit), .resEnCount(resEnCount)
);

// File: tb/sim_cgcam_top.sv
`timescale 1ns/1ps
module sim_cgcam_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [5:0]  wrAddr;
  logic [15:0] wrTag;
  logic        invEn;
  logic [5:0]  invAddr;
  logic        srchEn;
  logic [15:0] srchTag;
  logic        resValid;
  logic        resHit;
  logic [5:0]  resIdx;
  logic [3:0]  resEnCount;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  cgcam_top u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrTag(wrTag),
    .invEn(invEn), .invAddr(invAddr), .srchEn(srchEn), .srchTag(srchTag),
    .resValid(resValid), .resHit(resHit), .resIdx(resIdx),
    .resEnCount(resEnCount)
  );

  typedef struct packed {
    logic        isSrch;
    logic [5:0]  addr;
    logic [15:0] tag;
    logic        expHit;
    logic [5:0]  expIdx;
    logic [3:0]  expCnt;
  } vec_t;

  // Writes, then searches; sub-block g = entries 8g..8g+7, short key = low byte.
  localparam vec_t VECS [13] = '{
    '{1'b0, 6'd3,  16'h1234, 1'b0, 6'd0,  4'd0},
    '{1'b0, 6'd10, 16'hAB34, 1'b0, 6'd0,  4'd0},
    '{1'b0, 6'd20, 16'h1234, 1'b0, 6'd0,  4'd0},
    '{1'b0, 6'd63, 16'h0055, 1'b0, 6'd0,  4'd0},
    '{1'b0, 6'd40, 16'h7781, 1'b0, 6'd0,  4'd0},
    '{1'b1, 6'd0,  16'h1234, 1'b1, 6'd3,  4'd3},  // R4 lowest of 3 and 20
    '{1'b1, 6'd0,  16'hAB34, 1'b1, 6'd10, 4'd3},  // R2
    '{1'b1, 6'd0,  16'h5534, 1'b0, 6'd0,  4'd3},  // R8 short key only
    '{1'b1, 6'd0,  16'h0055, 1'b1, 6'd63, 4'd1},
    '{1'b1, 6'd0,  16'h7781, 1'b1, 6'd40, 4'd1},
    '{1'b1, 6'd0,  16'h0000, 1'b0, 6'd0,  4'd0},  // R3
    '{1'b1, 6'd0,  16'h9981, 1'b0, 6'd0,  4'd1},  // R8
    '{1'b1, 6'd0,  16'h0031, 1'b0, 6'd0,  4'd0}   // R7 slices match different entries
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic doWrite(input logic [5:0] a, input logic [15:0] t);
    wrEn = 1'b1; wrAddr = a; wrTag = t;
    @(negedge clk);
    wrEn = 1'b0; invEn = 1'b0;
  endtask

  task automatic doInv(input logic [5:0] a);
    invEn = 1'b1; invAddr = a;
    @(negedge clk);
    invEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Any wrEn/invEn already set share the search cycle.
  task automatic doSearch(input logic [15:0] t, input logic eHit,
                          input logic [5:0] eIdx, input logic [3:0] eCnt,
                          input string req);
    srchEn = 1'b1; srchTag = t;
    @(negedge clk);
    srchEn = 1'b0; wrEn = 1'b0; invEn = 1'b0;
    check("R2 latency", int'(resValid), 0);
    @(negedge clk);
    check("R2 valid", int'(resValid), 1);
    check(req, int'(resHit), int'(eHit));
    check(req, int'(resIdx), int'(eIdx));
    check("R7 count", int'(resEnCount), int'(eCnt));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finishRun();
    end
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrAddr = '0; wrTag = '0;
    invEn = 1'b0; invAddr = '0; srchEn = 1'b0; srchTag = '0;
    idle(3);
    // R1 reset state
    check("R1", int'(resValid), 0);
    check("R1", int'(resHit), 0);
    check("R1", int'(resIdx), 0);
    check("R1", int'(resEnCount), 0);
    rstN = 1'b1;
    idle(1);
    doSearch(16'h1234, 1'b0, 6'd0, 4'd0, "R1");

    for (int i = 0; i < 13; i++) begin
      if (VECS[i].isSrch)
        doSearch(VECS[i].tag, VECS[i].expHit, VECS[i].expIdx, VECS[i].expCnt,
                 VECS[i].expHit ? "R2" : "R3");
      else
        doWrite(VECS[i].addr, VECS[i].tag);
    end

    // R5 write and search in one cycle, then search right after a write
    wrEn = 1'b1; wrAddr = 6'd5; wrTag = 16'hC0DE;
    doSearch(16'hC0DE, 1'b1, 6'd5, 4'd1, "R5");
    doWrite(6'd6, 16'hBEEF);
    doSearch(16'hBEEF, 1'b1, 6'd6, 4'd1, "R5");

    // R9 overwrite: stale bits keep group 7 enabled for the old tag
    doWrite(6'd63, 16'h1166);
    doSearch(16'h0055, 1'b0, 6'd0, 4'd1, "R9");
    doSearch(16'h1166, 1'b1, 6'd63, 4'd1, "R9");

    // R6 invalidate in the search cycle hides entry 3
    invEn = 1'b1; invAddr = 6'd3;
    doSearch(16'h1234, 1'b1, 6'd20, 4'd3, "R6");
    idle(3);
    doSearch(16'hAB34, 1'b1, 6'd10, 4'd2, "R6");
    // R10 group 0 no longer enabled
    doSearch(16'h1234, 1'b1, 6'd20, 4'd2, "R10");

    // R11 rewrite entry 20 in the cycle its second slice would be cleared
    doInv(6'd20);
    idle(1);
    doWrite(6'd20, 16'h1234);
    idle(3);
    doSearch(16'h1234, 1'b1, 6'd20, 4'd2, "R11");

    // R12 invalidate and write to entry 40 together: write wins
    invEn = 1'b1; invAddr = 6'd40;
    doWrite(6'd40, 16'h2222);
    idle(3);
    doSearch(16'h2222, 1'b1, 6'd40, 4'd1, "R12");
    doSearch(16'h7781, 1'b0, 6'd0, 4'd1, "R12");

    done = 1'b1;
    finishRun();
  end

endmodule